// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache that sits between a processor load/store port and a word-wide memory port. It has 64 lines of 16 bytes. Each line keeps a valid flag, a 22-bit tag and four 32-bit words. A read that finds its line returns the selected word in the same cycle. A read that misses holds the processor in stall while the whole line is fetched from memory as four word reads. The read then completes from the refilled line.

Every store is sent to memory through a four-entry queue, so the processor moves on without waiting for memory. A store that hits also updates the cached word. A store that misses leaves the cache untouched and does not fetch the line. The processor stalls on a store only when the queue already holds four entries. Before a line fill starts, the queue is emptied, so a fill never reads a memory word that still has a store pending.

The processor holds its request, and all request fields, steady while `cpu_stall` is high. An access completes on the first rising edge at which `cpu_req` is high and `cpu_stall` is low.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid. The memory port is idle, and the first read of any address misses and causes exactly four memory reads.
- R2: A byte address splits into an offset in bits [3:0], a line index in bits [9:4] and a tag in bits [31:10]. Two addresses with the same index and different tags evict each other (for example, 1200 and 2224 both use line 11).
- R3: A read whose line is valid with a matching tag completes without stall and without memory traffic. It returns the word selected by address bits [3:2].
- R4: A read miss keeps `cpu_stall` high, reads the four words of the line at line base + 0, 4, 8 and 12, and completes only after the fourth word has arrived.
- R5: A store that hits updates the cached word, so a later read returns the new value without a fill. The store also reaches memory.
- R6: A store that misses causes no memory read and does not fill the line. The data reaches memory, and a later read of that line misses.
- R7: The store queue holds 4 entries. A store is accepted with no stall while the queue is not full, and `cpu_stall` is high for a store while 4 entries are queued.
- R8: No memory read transfer takes place while any accepted store has not yet been written to memory.
- R9: Queued stores reach memory in the order they were accepted.
- R10: A memory transfer happens on a rising edge with `mem_req` and `mem_ready` both high. Until then `mem_req`, `mem_we` and `mem_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the load completes |
| cpu_stall | output | 1 | Processor must hold the request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts or answers the transfer |

## Verification
The bench aims at lines that conflict on the same index. A design that compares tags wrongly would hit on 2224 after 1200 and return stale data. Stores that miss are checked for not refilling the line; a design that allocates on a store miss would turn the next read into a hit. The bench also stalls memory so the store queue fills. A design that drops or reorders a queued store leaves the wrong final word in memory. A design that starts a fill before the queue drains reads an old value.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} dc_state_t;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } wq_entry_t;
endpackage

// File: rtl/dc_wqueue.sv
module dc_wqueue #(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  dc_pkg::wq_entry_t push_ent,
  input  logic              pop,
  output dc_pkg::wq_entry_t head,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0] DEPTH_C = (PTR_W+1)'(DEPTH);

  dc_pkg::wq_entry_t slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [PTR_W:0]   fill_q, fill_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_ent;
  end

  assign head  = slot_q[rd_ptr_q];
  assign full  = (fill_q == DEPTH_C);
  assign empty = (fill_q == '0);

  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dc_lines.sv
module dc_lines #(
  parameter int LINES = 64,
  parameter int WORDS = 4,
  parameter int TAG_W = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LINES)-1:0] look_idx,
  input  logic [$clog2(WORDS)-1:0] look_wsel,
  input  logic [TAG_W-1:0]         look_tag,
  output logic                     hit,
  output logic [31:0]              look_word,
  input  logic                     wr_en,
  input  logic [$clog2(LINES)-1:0] wr_idx,
  input  logic [$clog2(WORDS)-1:0] wr_wsel,
  input  logic [31:0]              wr_data,
  input  logic                     v_we,
  input  logic                     v_set,
  input  logic [$clog2(LINES)-1:0] v_idx,
  input  logic [TAG_W-1:0]         v_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [31:0]      word_q [LINES][WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (v_we) valid_q[v_idx] <= v_set;
  end

  always_ff @(posedge clk) begin
    if (v_we && v_set) tag_q[v_idx] <= v_tag;
  end

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_idx][wr_wsel] <= wr_data;
  end

  assign hit       = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
  assign look_word = word_q[look_idx][look_wsel];

  assert_valid_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_we && !v_set) |=> !valid_q[$past(v_idx)]);
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16,
  parameter int WQ_DEPTH   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  import dc_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int TAG_W  = 32 - IDX_W - OFF_W;
  localparam logic [WSEL_W-1:0] LAST_W = WSEL_W'(WORDS - 1);

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_wsel;
  logic              dc_unused_lsb;

  assign a_tag         = cpu_addr[31 -: TAG_W];
  assign a_idx         = cpu_addr[OFF_W +: IDX_W];
  assign a_wsel        = cpu_addr[2 +: WSEL_W];
  assign dc_unused_lsb = ^cpu_addr[1:0];

  dc_state_t         state_q, state_d;
  logic [WSEL_W-1:0] beat_q, beat_d;

  logic              hit, wq_full, wq_empty, wq_push, wq_pop;
  wq_entry_t         wq_head, wq_in;
  logic              wr_en, v_we, v_set;
  logic [WSEL_W-1:0] wr_wsel;
  logic [31:0]       wr_data;
  logic              rd_miss, st_take;

  assign rd_miss = cpu_req && !cpu_we && !hit;
  assign st_take = cpu_req && cpu_we && !wq_full && (state_q == ST_IDLE);
  assign wq_push = st_take;
  assign wq_in   = '{addr: cpu_addr, data: cpu_wdata};

  assign cpu_stall = cpu_req && (cpu_we ? (wq_full || state_q != ST_IDLE) : !hit);

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    wq_pop    = 1'b0;
    v_we      = 1'b0;
    v_set     = 1'b0;
    wr_en     = st_take && hit;
    wr_wsel   = a_wsel;
    wr_data   = cpu_wdata;
    case (state_q)
      ST_IDLE: begin
        if (!wq_empty) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = wq_head.addr;
          mem_wdata = wq_head.data;
          wq_pop    = mem_ready;
        end else if (rd_miss) begin
          state_d = ST_FILL;
          beat_d  = '0;
          v_we    = 1'b1;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {a_tag, a_idx, beat_q, 2'b00};
        if (mem_ready) begin
          wr_en   = 1'b1;
          wr_wsel = beat_q;
          wr_data = mem_rdata;
          beat_d  = beat_q + 1'b1;
          if (beat_q == LAST_W) begin
            v_we    = 1'b1;
            v_set   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  dc_lines #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_idx  (a_idx),
    .look_wsel (a_wsel),
    .look_tag  (a_tag),
    .hit       (hit),
    .look_word (cpu_rdata),
    .wr_en     (wr_en),
    .wr_idx    (a_idx),
    .wr_wsel   (wr_wsel),
    .wr_data   (wr_data),
    .v_we      (v_we),
    .v_set     (v_set),
    .v_idx     (a_idx),
    .v_tag     (a_tag)
  );

  dc_wqueue #(.DEPTH(WQ_DEPTH)) u_wq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wq_push),
    .push_ent (wq_in),
    .pop      (wq_pop),
    .head     (wq_head),
    .full     (wq_full),
    .empty    (wq_empty)
  );

  assert_fill_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> wq_empty);
  assert_fill_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> cpu_stall);
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_no_write_in_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> !wq_push);
endmodule

// File: tb/sim_wt_dcache.sv
module sim_wt_dcache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;

  always #10 clk = ~clk;

  wt_dcache u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  int tests = 0, fails = 0, cycles = 0;
  int rd_cnt = 0, wr_cnt = 0, wr_issued = 0;
  bit mem_hold = 1'b0, done = 1'b0;
  logic [7:0]  lfsr = 8'h5a;
  logic [31:0] mem [1024];
  logic [31:0] shadow [1024];
  logic [31:0] exp_q [$];

  function automatic logic [31:0] seed_word(int i);
    return (32'(i) * 32'h01010101) ^ 32'hA5000000;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural memory with a pseudo-random ready
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= !mem_hold && (lfsr[0] || lfsr[2]);
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= seed_word(i);
    end else if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt++;
      end else begin
        chk(wr_cnt == wr_issued, "R8 read while store pending", 32'(wr_cnt), 32'(wr_issued));
        rd_cnt++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_req && !cpu_we && !cpu_stall) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read", cpu_rdata, '0);
      else chk(cpu_rdata == exp_q[0], "R3 read data", cpu_rdata, exp_q[0]);
      if (exp_q.size() != 0) void'(exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input bit expect_full, output int waits, output int reads);
    int r0;
    r0 = rd_cnt;
    if (we) shadow[a[11:2]] = d;
    else exp_q.push_back(shadow[a[11:2]]);
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waits = 0;
    forever begin
      @(negedge clk);
      if (expect_full && waits == 0) begin
        chk(cpu_stall == 1'b1, "R7 stall when queue full", 32'(cpu_stall), 32'd1);
        mem_hold = 1'b0;
      end
      if (!cpu_stall) break;
      waits++;
    end
    if (we) wr_issued++;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    reads = rd_cnt - r0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && wr_cnt != wr_issued; k++) @(posedge clk);
    @(negedge clk);
  endtask

  int w, r;
  initial begin
    for (int i = 0; i < 1024; i++) shadow[i] = seed_word(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_stall && !mem_req, "R1 idle after reset", {30'd0, cpu_stall, mem_req}, '0);

    access(0, 32'd1200, '0, 0, w, r);
    chk(r == 4, "R1 first read fills", 32'(r), 32'd4);
    chk(w >= 5, "R4 stall through fill", 32'(w), 32'd5);
    access(0, 32'd1204, '0, 0, w, r);
    chk(r == 0 && w == 0, "R3 hit no traffic", 32'(r + w), 32'd0);
    access(0, 32'd1212, '0, 0, w, r);
    chk(r == 0, "R3 last word hit", 32'(r), 32'd0);
    access(0, 32'd2224, '0, 0, w, r);
    chk(r == 4, "R2 conflict on line 11", 32'(r), 32'd4);
    access(0, 32'd1200, '0, 0, w, r);
    chk(r == 4, "R2 evicted line refills", 32'(r), 32'd4);
    access(0, 32'd1072, '0, 0, w, r);
    chk(r == 4, "R2 other index misses", 32'(r), 32'd4);

    access(1, 32'd1208, 32'hCAFE0001, 0, w, r);
    chk(w == 0 && r == 0, "R7 store no stall", 32'(w + r), 32'd0);
    access(0, 32'd1208, '0, 0, w, r);
    chk(r == 0, "R5 store hit keeps line", 32'(r), 32'd0);
    drain();
    chk(mem[1208 >> 2] == 32'hCAFE0001, "R5 store hit reaches memory", mem[1208 >> 2], 32'hCAFE0001);

    access(1, 32'd3000, 32'hBEEF0002, 0, w, r);
    chk(r == 0, "R6 store miss no fill", 32'(r), 32'd0);
    drain();
    chk(mem[3000 >> 2] == 32'hBEEF0002, "R6 store miss reaches memory", mem[3000 >> 2], 32'hBEEF0002);
    access(0, 32'd3000, '0, 0, w, r);
    chk(r == 4, "R6 line not allocated", 32'(r), 32'd4);

    access(1, 32'd400, 32'h11110000, 0, w, r);
    access(1, 32'd404, 32'h22220000, 0, w, r);
    access(1, 32'd408, 32'h33330000, 0, w, r);
    access(0, 32'd404, '0, 0, w, r);
    chk(r == 4, "R8 fill after drain", 32'(r), 32'd4);

    drain();
    mem_hold = 1'b1;
    repeat (2) @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      access(1, 32'd3600, 32'hD0000000 + 32'(k), 0, w, r);
      chk(w == 0, "R7 store accepted while not full", 32'(w), 32'd0);
    end
    access(1, 32'd3600, 32'hD0000004, 1, w, r);
    drain();
    chk(mem[3600 >> 2] == 32'hD0000004, "R9 stores in order", mem[3600 >> 2], 32'hD0000004);
    chk(wr_cnt == wr_issued, "R9 all stores written", 32'(wr_cnt), 32'(wr_issued));
    access(0, 32'd3600, '0, 0, w, r);
    chk(r == 4, "R10 read after held memory", 32'(r), 32'd4);

    repeat (2) @(posedge clk);
    chk(exp_q.size() == 0, "R3 all reads completed", 32'(exp_q.size()), '0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule